// File: doc/BRIEF.md
# Group vector-length setter

This block runs the 32-bit vector-length word that opens an instruction group. From that word it works out new values for the active vector length (VL), the maximum vector length (MAXVL) and the sub-vector length (SUBVL). It holds these three values in registers and drives them out for the rest of the datapath. If the word names a nonzero destination register, the block also copies the resulting length into that scalar register.

The word can be used in two ways. In loop mode the candidate length is either a 5-bit immediate or the value read from a named scalar register. That candidate is then cut down so that it never exceeds the MAXVL already held. In one-shot mode a 6-bit immediate sets MAXVL and VL together. The block has one register-file read port and one write port, both driven by a small state machine. A start strobe is accepted only in the idle state, and a single-cycle done strobe marks each commit.

The state machine has three states. `ST_IDLE` waits for a start. `ST_FETCH` is the register-read cycle in loop mode with a register source. `ST_DONE` is the cycle that pulses done and carries the write-back. Its transitions are:

- idle to done (accept): an immediate-source start commits at the accept edge.
- idle to fetch (accept): a register-source start goes to the read cycle.
- fetch to done (commit): the read value is clamped and committed.
- done to idle (release): always taken after one cycle.

Top module: `vlgrp_setter`

Word fields:

| Bits | Field |
| --- | --- |
| 30 | mode select (0 loop, 1 one-shot) |
| 31 | ignored |
| 29:28 | sub-vector length |
| 27:22 | destination register index |
| 21:17 | loop immediate, or source register index in loop mode |
| 16 | in loop mode, selects a register source (1) or the immediate (0) |
| 21:16 | in one-shot mode, the 6-bit immediate |

## Requirements
- R1: After reset, VL, MAXVL and SUBVL are 0, and done, write enable, read enable and busy are all low.
- R2: A loop-mode start (bit 30 = 0, bit 16 = 0) commits VL = min(bits 21:17, MAXVL) and leaves MAXVL unchanged. Done is high in the cycle after the accepting edge.
- R3: A loop-mode start with bit 16 = 1 raises read enable in the cycle after the accepting edge, with read address equal to bits 21:17. The read data of that cycle, clamped to MAXVL, becomes VL. Done is high two cycles after the accepting edge.
- R4: VL never exceeds MAXVL.
- R5: A one-shot start (bit 30 = 1) sets both MAXVL and VL to bits 21:16. Done is high in the cycle after the accepting edge.
- R6: Bits 29:28 are loaded into SUBVL at each commit, in both modes.
- R7: When bits 27:22 are nonzero, write enable is high in the done cycle only. The write address is bits 27:22 and the write data is the new VL, zero-extended.
- R8: When bits 27:22 are zero, no register write happens.
- R9: A start that arrives while busy is ignored: it causes no commit and no extra done.
- R10: Done is a one-cycle pulse, and busy is high from the cycle after acceptance through the done cycle.
- R11: Bit 31 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | start strobe, taken only when idle |
| blk_i | input | 32 | vector-length word |
| rd_en_o | output | 1 | register read request |
| rd_addr_o | output | 5 | register read index |
| rd_data_i | input | XLEN | read data, valid in the same cycle |
| wr_en_o | output | 1 | register write enable |
| wr_addr_o | output | 6 | register write index |
| wr_data_o | output | XLEN | register write data |
| vl_o | output | VLW | current vector length |
| maxvl_o | output | VLW | current maximum vector length |
| subvl_o | output | 2 | current sub-vector length |
| busy_o | output | 1 | an operation is in flight |
| done_o | output | 1 | commit strobe |

## Verification
The assertions assume that the register file answers a read in the same cycle, with data that stays stable while read enable is high. They also assume that start is sampled cleanly at the clock edge. The bench serves reads combinationally from its own register array, which it changes only between operations. It drives start and the word only at falling edges, so every property sees settled inputs. A start issued during the fetch cycle tests the ignore rule without breaking these assumptions.

// File: rtl/vlgrp_pkg.sv
package vlgrp_pkg;

    localparam int BLK_W  = 32;
    localparam int SRC_W  = 5;
    localparam int DST_W  = 6;
    localparam int SUB_W  = 2;
    localparam int WIMM_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DONE
    } vlg_state_e;

    typedef struct packed {
        logic              oneshot;
        logic              reg_src;
        logic [SUB_W-1:0]  subvl;
        logic [DST_W-1:0]  dest;
        logic [SRC_W-1:0]  src_idx;
        logic [WIMM_W-1:0] wide_imm;
    } vlg_fields_t;

endpackage

// File: rtl/vlgrp_decode.sv
module vlgrp_decode
    import vlgrp_pkg::*;
(
    input  logic [BLK_W-1:0] blk_i,
    output vlg_fields_t      fld_o
);
    always_comb begin
        fld_o.oneshot  = blk_i[30];
        fld_o.reg_src  = ~blk_i[30] & blk_i[16];
        fld_o.subvl    = blk_i[29:28];
        fld_o.dest     = blk_i[27:22];
        fld_o.src_idx  = blk_i[21:17];
        fld_o.wide_imm = blk_i[21:16];
    end
endmodule

// File: rtl/vlgrp_clamp.sv
module vlgrp_clamp #(
    parameter int CW = 32,
    parameter int LW = 6
) (
    input  logic [CW-1:0] cand_i,
    input  logic [LW-1:0] limit_i,
    output logic [LW-1:0] res_o
);
    localparam int EW = (CW > LW) ? CW : LW;

    logic [EW-1:0] cand_x;
    logic [EW-1:0] limit_x;

    always_comb begin
        cand_x  = EW'(cand_i);
        limit_x = EW'(limit_i);
        res_o   = (cand_x > limit_x) ? limit_i : cand_x[LW-1:0];
    end
endmodule

// File: rtl/vlgrp_setter.sv
module vlgrp_setter
    import vlgrp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLW  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [BLK_W-1:0]    blk_i,
    output logic                rd_en_o,
    output logic [SRC_W-1:0]    rd_addr_o,
    input  logic [XLEN-1:0]     rd_data_i,
    output logic                wr_en_o,
    output logic [DST_W-1:0]    wr_addr_o,
    output logic [XLEN-1:0]     wr_data_o,
    output logic [VLW-1:0]      vl_o,
    output logic [VLW-1:0]      maxvl_o,
    output logic [SUB_W-1:0]    subvl_o,
    output logic                busy_o,
    output logic                done_o
);
    vlg_state_e  state_q, state_d;
    vlg_fields_t fld_in, fld_q;
    logic [VLW-1:0]   vl_q, maxvl_q, vl_d, maxvl_d;
    logic [SUB_W-1:0] subvl_q, subvl_d;
    logic             accept;
    logic [XLEN-1:0]  cand;
    logic [VLW-1:0]   clamped;

    vlgrp_decode u_dec (
        .blk_i (blk_i),
        .fld_o (fld_in)
    );

    assign cand = (state_q == ST_FETCH) ? rd_data_i : XLEN'(fld_in.src_idx);

    vlgrp_clamp #(.CW(XLEN), .LW(VLW)) u_clamp (
        .cand_i  (cand),
        .limit_i (maxvl_q),
        .res_o   (clamped)
    );

    assign accept = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_d = state_q;
        vl_d    = vl_q;
        maxvl_d = maxvl_q;
        subvl_d = subvl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (fld_in.reg_src) begin
                        state_d = ST_FETCH;
                    end else begin
                        state_d = ST_DONE;
                        subvl_d = fld_in.subvl;
                        if (fld_in.oneshot) begin
                            vl_d    = VLW'(fld_in.wide_imm);
                            maxvl_d = VLW'(fld_in.wide_imm);
                        end else begin
                            vl_d = clamped;
                        end
                    end
                end
            end
            ST_FETCH: begin
                state_d = ST_DONE;
                vl_d    = clamped;
                subvl_d = fld_q.subvl;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fld_q   <= '0;
            vl_q    <= '0;
            maxvl_q <= '0;
            subvl_q <= '0;
        end else begin
            state_q <= state_d;
            vl_q    <= vl_d;
            maxvl_q <= maxvl_d;
            subvl_q <= subvl_d;
            if (accept) begin
                fld_q <= fld_in;
            end
        end
    end

    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
        rd_en_o   = (state_q == ST_FETCH);
        rd_addr_o = fld_q.src_idx;
        wr_en_o   = (state_q == ST_DONE) && (fld_q.dest != '0);
        wr_addr_o = fld_q.dest;
        wr_data_o = XLEN'(vl_q);
        vl_o      = vl_q;
        maxvl_o   = maxvl_q;
        subvl_o   = subvl_q;
    end

endmodule

// File: rtl/vlgrp_setter_chk.sv
module vlgrp_setter_chk
    import vlgrp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLW  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rd_en_o,
    input logic             wr_en_o,
    input logic [DST_W-1:0] wr_addr_o,
    input logic [XLEN-1:0]  wr_data_o,
    input logic [VLW-1:0]   vl_o,
    input logic [VLW-1:0]   maxvl_o,
    input logic             busy_o,
    input logic             done_o
);
    a_r4_vl_within_max: assert property (@(posedge clk) disable iff (!rst_n)
        vl_o <= maxvl_o);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r3_fetch_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> (done_o && !rd_en_o));

    a_r7_write_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (done_o && wr_data_o == XLEN'(vl_o)));

    a_r8_no_write_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o != '0));

    a_r9_start_in_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && $stable(vl_o) && $stable(maxvl_o)));
endmodule

bind vlgrp_setter vlgrp_setter_chk #(.XLEN(XLEN), .VLW(VLW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .vl_o      (vl_o),
    .maxvl_o   (maxvl_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/vlgrp_setter_test.sv
module vlgrp_setter_test;
    localparam int XLEN = 32;
    localparam int VLW  = 6;

    typedef struct {
        int    vl;
        int    maxvl;
        int    subvl;
        int    wen;
        int    waddr;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [31:0]     blk_i = '0;
    logic            rd_en_o, wr_en_o, busy_o, done_o;
    logic [4:0]      rd_addr_o;
    logic [5:0]      wr_addr_o;
    logic [XLEN-1:0] rd_data_i, wr_data_o;
    logic [VLW-1:0]  vl_o, maxvl_o;
    logic [1:0]      subvl_o;

    logic [XLEN-1:0] rf [32];
    exp_t            sb [$];
    int              total = 0;
    int              bad = 0;
    int              maxvl_m = 0;
    bit              finished = 0;

    always #2.5 clk = ~clk;

    always_comb rd_data_i = rf[rd_addr_o];

    vlgrp_setter #(.XLEN(XLEN), .VLW(VLW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_i(blk_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .vl_o(vl_o), .maxvl_o(maxvl_o), .subvl_o(subvl_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_loop(bit b31, int sub, int dst, int v5, bit vlt);
        return {b31, 1'b0, 2'(sub), 6'(dst), 5'(v5), vlt, 16'h0000};
    endfunction

    function automatic logic [31:0] mk_os(bit b31, int sub, int dst, int imm6);
        return {b31, 1'b1, 2'(sub), 6'(dst), 6'(imm6), 16'h0000};
    endfunction

    // Reference model: pushes the expected commit and updates the model MAXVL.
    function automatic bit predict(logic [31:0] b, string tag);
        exp_t e;
        bit   rsrc;
        longint cand;
        rsrc = !b[30] && b[16];
        if (b[30]) begin
            e.vl    = int'(b[21:16]);
            maxvl_m = e.vl;
        end else begin
            cand = rsrc ? longint'(rf[b[21:17]]) : longint'(b[21:17]);
            e.vl = (cand > longint'(maxvl_m)) ? maxvl_m : int'(cand);
        end
        e.maxvl = maxvl_m;
        e.subvl = int'(b[29:28]);
        e.waddr = int'(b[27:22]);
        e.wen   = (e.waddr != 0) ? 1 : 0;
        e.tag   = tag;
        sb.push_back(e);
        return rsrc;
    endfunction

    task automatic run_op(input logic [31:0] b, input string tag);
        bit rsrc;
        rsrc = predict(b, tag);
        @(negedge clk);
        start_i = 1'b1;
        blk_i   = b;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, {tag, " R10 busy after accept"}, int'(busy_o), 1);
        if (rsrc) begin
            chk(rd_en_o == 1'b1, {tag, " R3 read enable"}, int'(rd_en_o), 1);
            chk(rd_addr_o == b[21:17], {tag, " R3 read address"}, int'(rd_addr_o), int'(b[21:17]));
            @(negedge clk);
        end
        chk(done_o == 1'b1, {tag, " done latency"}, int'(done_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R10 done single pulse"}, int'(done_o), 0);
        chk(wr_en_o == 1'b0, {tag, " R7 write only in done"}, int'(wr_en_o), 0);
    endtask

    // Monitor: compares every commit against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (wr_en_o && !done_o) begin
                chk(1'b0, "R7 write outside done", 1, 0);
            end
            if (done_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(vl_o) == e.vl, {e.tag, " vl"}, int'(vl_o), e.vl);
                    chk(int'(maxvl_o) == e.maxvl, {e.tag, " maxvl"}, int'(maxvl_o), e.maxvl);
                    chk(int'(subvl_o) == e.subvl, {e.tag, " R6 subvl"}, int'(subvl_o), e.subvl);
                    chk(int'(wr_en_o) == e.wen, {e.tag, " R7/R8 write enable"}, int'(wr_en_o), e.wen);
                    if (e.wen != 0) begin
                        chk(int'(wr_addr_o) == e.waddr, {e.tag, " R7 write address"}, int'(wr_addr_o), e.waddr);
                        chk(wr_data_o == XLEN'(e.vl), {e.tag, " R7 write data"}, int'(wr_data_o), e.vl);
                    end
                end
            end
        end
    end

    task automatic report();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = XLEN'(i * 3);
        rf[7] = 32'd1000;
        rf[3] = 32'd7;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(vl_o == '0 && maxvl_o == '0 && subvl_o == '0, "R1 registers after reset",
            int'(vl_o) + int'(maxvl_o) + int'(subvl_o), 0);
        chk(!done_o && !wr_en_o && !rd_en_o && !busy_o, "R1 strobes after reset",
            int'(done_o) + int'(wr_en_o) + int'(rd_en_o) + int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(mk_loop(0, 1, 0, 17, 0), "R2 R4 R8 loop imm with MAXVL 0");
        run_op(mk_os(0, 2, 5, 40), "R5 R6 R7 one-shot 40");
        run_op(mk_loop(0, 0, 9, 25, 0), "R2 R7 loop imm 25 under 40");
        run_op(mk_os(0, 1, 0, 20), "R5 R8 one-shot 20");
        run_op(mk_loop(0, 3, 12, 31, 0), "R4 loop imm 31 clamped to 20");
        run_op(mk_loop(0, 0, 63, 7, 1), "R3 R4 reg source 1000 clamped");
        run_op(mk_loop(0, 3, 1, 3, 1), "R3 R6 reg source 7");
        run_op(mk_os(1, 0, 2, 63), "R11 one-shot with bit 31 set");
        run_op(mk_loop(1, 2, 4, 30, 0), "R11 loop imm with bit 31 set");

        // R9: a start during the fetch cycle is ignored
        begin
            logic [31:0] first;
            first = mk_loop(0, 1, 6, 3, 1);
            void'(predict(first, "R9 first op"));
            @(negedge clk);
            start_i = 1'b1;
            blk_i   = first;
            @(negedge clk);
            blk_i   = mk_os(0, 2, 8, 11);
            chk(rd_en_o == 1'b1, "R9 fetch in progress", int'(rd_en_o), 1);
            @(negedge clk);
            start_i = 1'b0;
            chk(done_o == 1'b1, "R9 first op done", int'(done_o), 1);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(done_o == 1'b0, "R9 no extra done", int'(done_o), 0);
                chk(int'(maxvl_o) == maxvl_m, "R9 MAXVL untouched", int'(maxvl_o), maxvl_m);
            end
        end

        chk(sb.size() == 0, "R10 all commits seen", sb.size(), 0);
        repeat (2) @(negedge clk);
        report();
    end
endmodule